// File: doc/BRIEF.md
# Shared-Function Bidirectional I/O Port

This block is an eight-pin general-purpose I/O port whose pins are also claimed by other functions. Each pin has a direction bit and an output data latch, and its pad level can be read back. Software reaches the port through a small synchronous register bus. A 2-bit address picks the port, latch or direction register. Writes land on a clock edge, and read data is combinational.

The pins fall into two groups. The upper group (pins 7:4) can be handed to four analog input channels. The upper two of those pins can instead carry two PWM outputs, B on pin 7 and C on pin 6. The lower group (pins 3:0) can carry external address bits 19:16 when the system bus owns them. Configuration inputs pick each group's function. They pass through a register stage, so each group sits in its own default mode while reset is held: analog for the upper group and bus for the lower group. Each pad sees a priority mux. Routed PWM wins over analog, and analog wins over GPIO. On the lower pins, bus mode wins over GPIO.

Top module: `mux_gpio_port`

## Requirements
- R1: While reset is asserted and right after it, the latch reads 0x00, the direction register reads 0xFF, pins 7:4 are in analog mode, pins 3:0 are in bus mode and PWM is not routed, whatever the configuration inputs are.
- R2: In GPIO mode a direction bit of 1 turns off that pin's driver (pad_oe = 0), and a direction bit of 0 drives the latch bit onto pad_out with pad_oe = 1.
- R3: A write to address 0 (port) or address 1 (latch) loads the output latch. A read of address 1 returns the latched value, not the pad level.
- R4: Address 2 reads and writes the direction register. A write to address 3 changes neither the latch nor the direction register, and a read of address 3 returns 0.
- R5: A read of address 0 returns pad_in through a two-flop synchronizer. A pad change made before a rising edge shows on the read only after the second rising edge.
- R6: When the analog configuration is set, pins 7:4 are not driven and their bits read as 0 at address 0.
- R7: When the bus configuration is set, pins 3:0 are driven (pad_oe = 1) with ext_addr_hi, whatever the direction bits are.
- R8: When cfg_pwm_route_n is 0 and pwm_en is 1, pin 7 drives pwm_b and pin 6 drives pwm_c, ahead of both analog and GPIO modes. pad_out follows the PWM inputs in the same cycle.
- R9: A change on the configuration inputs takes effect on the pins and in the readback one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cfg_analog_hi | input | 1 | 1 puts pins 7:4 in analog mode |
| cfg_bus_lo | input | 1 | 1 gives pins 3:0 to the external address bus |
| cfg_pwm_route_n | input | 1 | 0 routes the PWM outputs to pins 7 and 6 |
| pwm_en | input | 1 | PWM outputs active |
| pwm_b | input | 1 | PWM output B (pin 7) |
| pwm_c | input | 1 | PWM output C (pin 6) |
| ext_addr_hi | input | 4 | External address bits 19:16 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A wrong latch or direction bit shows on pad_out or pad_oe at the first negative edge after the write edge, and also on a latch or direction read at the same moment. A wrong registered configuration shows one edge after the configuration inputs change, as a pad driven when it should float, or as upper port bits read as nonzero while the group is in analog mode. A synchronizer that is too short or too long shows as a port read that changes one cycle too early or too late after a pad step. The bench steps the pad and reads at both the first and the second edge to catch either error.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    RA_PORT  = 2'd0,
    RA_LATCH = 2'd1,
    RA_DIR   = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  // Registered per-group function selection
  typedef struct packed {
    logic hi_analog;
    logic lo_bus;
    logic pwm_route_n;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{hi_analog: 1'b1, lo_bus: 1'b1, pwm_route_n: 1'b1};

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  input  pin_cfg_t      cfg_in,
  output logic [PW-1:0] lat_o,
  output logic [PW-1:0] dir_o,
  output pin_cfg_t      cfg_o
);
  logic [PW-1:0] lat_q, lat_d;
  logic [PW-1:0] dir_q, dir_d;
  pin_cfg_t      cfg_q;
  logic          lat_en, dir_en;
  reg_addr_e     sel;

  assign sel    = reg_addr_e'(addr);
  assign lat_en = we && (sel == RA_PORT || sel == RA_LATCH);
  assign dir_en = we && (sel == RA_DIR);

  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    if (lat_en) lat_d = wdata;
    if (dir_en) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      cfg_q <= CFG_RESET;
    end else begin
      lat_q <= lat_d;
      dir_q <= dir_d;
      cfg_q <= cfg_in;
    end
  end

  assign lat_o = lat_q;
  assign dir_o = dir_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int PW   = 8,
  parameter int LO_N = 4
) (
  input  pin_cfg_t        cfg,
  input  logic [PW-1:0]   lat,
  input  logic [PW-1:0]   dir,
  input  logic            pwm_en,
  input  logic            pwm_b,
  input  logic            pwm_c,
  input  logic [LO_N-1:0] ext_addr,
  output logic [PW-1:0]   pad_out,
  output logic [PW-1:0]   pad_oe
);
  logic alt_on;
  assign alt_on = ~cfg.pwm_route_n & pwm_en;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    if (i < LO_N) begin : g_bus
      always_comb begin
        if (cfg.lo_bus) begin
          pad_out[i] = ext_addr[i];
          pad_oe[i]  = 1'b1;
        end else begin
          pad_out[i] = lat[i];
          pad_oe[i]  = ~dir[i];
        end
      end
    end else if (i >= PW - 2) begin : g_alt
      localparam bit IS_B = (i == PW - 1);
      logic alt_v;
      assign alt_v = IS_B ? pwm_b : pwm_c;
      always_comb begin
        if (alt_on) begin
          pad_out[i] = alt_v;
          pad_oe[i]  = 1'b1;
        end else if (cfg.hi_analog) begin
          pad_out[i] = 1'b0;
          pad_oe[i]  = 1'b0;
        end else begin
          pad_out[i] = lat[i];
          pad_oe[i]  = ~dir[i];
        end
      end
    end else begin : g_ana
      always_comb begin
        if (cfg.hi_analog) begin
          pad_out[i] = 1'b0;
          pad_oe[i]  = 1'b0;
        end else begin
          pad_out[i] = lat[i];
          pad_oe[i]  = ~dir[i];
        end
      end
    end
  end
endmodule

// File: rtl/mux_gpio_port.sv
module mux_gpio_port
  import gpio_mux_pkg::*;
#(
  parameter int PW   = 8,
  parameter int LO_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [PW-1:0]   reg_wdata,
  output logic [PW-1:0]   reg_rdata,
  input  logic            cfg_analog_hi,
  input  logic            cfg_bus_lo,
  input  logic            cfg_pwm_route_n,
  input  logic            pwm_en,
  input  logic            pwm_b,
  input  logic            pwm_c,
  input  logic [LO_N-1:0] ext_addr_hi,
  input  logic [PW-1:0]   pad_in,
  output logic [PW-1:0]   pad_out,
  output logic [PW-1:0]   pad_oe
);
  localparam int HI_N = PW - LO_N;

  pin_cfg_t      cfg_in, cfg_q;
  logic [PW-1:0] lat, dir, pin_sync, rd_mask;

  assign cfg_in = '{hi_analog: cfg_analog_hi, lo_bus: cfg_bus_lo, pwm_route_n: cfg_pwm_route_n};

  gpio_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cfg_in(cfg_in), .lat_o(lat), .dir_o(dir), .cfg_o(cfg_q)
  );

  gpio_sync #(.W(PW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_pin_mux #(.PW(PW), .LO_N(LO_N)) u_mux (
    .cfg(cfg_q), .lat(lat), .dir(dir), .pwm_en(pwm_en), .pwm_b(pwm_b),
    .pwm_c(pwm_c), .ext_addr(ext_addr_hi), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Analog-mode pins read as zero
  assign rd_mask = {{HI_N{~cfg_q.hi_analog}}, {LO_N{1'b1}}};

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_PORT:  reg_rdata = pin_sync & rd_mask;
      RA_LATCH: reg_rdata = lat;
      RA_DIR:   reg_rdata = dir;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int PW   = 8,
  parameter int LO_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      reg_addr,
  input logic            reg_we,
  input logic [PW-1:0]   reg_wdata,
  input logic [PW-1:0]   reg_rdata,
  input logic            cfg_analog_hi,
  input logic            cfg_bus_lo,
  input logic            cfg_pwm_route_n,
  input logic            pwm_en,
  input logic            pwm_b,
  input logic            pwm_c,
  input logic [LO_N-1:0] ext_addr_hi,
  input logic [LO_N-1:0] pad_in_lo,
  input logic [PW-1:0]   pad_out,
  input logic [PW-1:0]   pad_oe
);
  assert_dir_write_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_we) && $past(reg_addr) == 2'd2 && !$past(cfg_bus_lo)
    |-> pad_oe[LO_N-1:0] == ~$past(reg_wdata[LO_N-1:0]));

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_we) && $past(reg_addr) <= 2'd1 && reg_addr == 2'd1
    |-> reg_rdata == $past(reg_wdata));

  assert_unused_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd3 |-> reg_rdata == '0);

  assert_sync_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rst_n, 2) && reg_addr == 2'd0
    |-> reg_rdata[LO_N-1:0] == $past(pad_in_lo, 2));

  assert_analog_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_analog_hi) && reg_addr == 2'd0
    |-> reg_rdata[PW-1:LO_N] == '0);

  assert_analog_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_analog_hi) |-> pad_oe[PW-3:LO_N] == '0);

  assert_bus_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_bus_lo)
    |-> pad_oe[LO_N-1:0] == '1 && pad_out[LO_N-1:0] == ext_addr_hi);

  assert_pwm_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(cfg_pwm_route_n) && pwm_en
    |-> pad_oe[PW-1:PW-2] == 2'b11 && pad_out[PW-1] == pwm_b && pad_out[PW-2] == pwm_c);
endmodule

bind mux_gpio_port gpio_port_checker #(.PW(PW), .LO_N(LO_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_analog_hi(cfg_analog_hi),
  .cfg_bus_lo(cfg_bus_lo), .cfg_pwm_route_n(cfg_pwm_route_n), .pwm_en(pwm_en),
  .pwm_b(pwm_b), .pwm_c(pwm_c), .ext_addr_hi(ext_addr_hi),
  .pad_in_lo(pad_in[LO_N-1:0]), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/mux_gpio_port_tb_top.sv
module mux_gpio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cfg_analog_hi, cfg_bus_lo, cfg_pwm_route_n;
  logic       pwm_en, pwm_b, pwm_c;
  logic [3:0] ext_addr_hi;
  logic [7:0] pad_in, pad_out, pad_oe;

  always #4 clk = ~clk;

  mux_gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_analog_hi(cfg_analog_hi),
    .cfg_bus_lo(cfg_bus_lo), .cfg_pwm_route_n(cfg_pwm_route_n), .pwm_en(pwm_en),
    .pwm_b(pwm_b), .pwm_c(pwm_c), .ext_addr_hi(ext_addr_hi), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    string      req;
    int         sel;   // 0 reg_rdata, 1 pad_out, 2 pad_oe
    logic [7:0] mask;
    logic [7:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_out(string req, int sel, logic [7:0] mask, logic [7:0] exp);
    exp_item_t it;
    it.req = req; it.sel = sel; it.mask = mask; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step();
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  // Monitor: compares 2 ns after each falling edge, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        act = (it.sel == 0) ? reg_rdata : (it.sel == 1) ? pad_out : pad_oe;
        n_chk++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h mask=%02h",
                   it.req, it.sel, act & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Driver
  initial begin
    rst_n = 1'b0; reg_addr = 2'd2; reg_we = 1'b0; reg_wdata = 8'h00;
    cfg_analog_hi = 1'b0; cfg_bus_lo = 1'b0; cfg_pwm_route_n = 1'b0;
    pwm_en = 1'b1; pwm_b = 1'b1; pwm_c = 1'b1; ext_addr_hi = 4'hA; pad_in = 8'h00;
    step(); step();
    // R1: group defaults hold under reset despite GPIO/PWM config inputs
    expect_out("R1 dir reset", 0, 8'hFF, 8'hFF);
    expect_out("R1 oe reset", 2, 8'hFF, 8'h0F);
    expect_out("R1 bus out reset", 1, 8'h0F, 8'h0A);
    step(); reg_addr = 2'd1;
    expect_out("R1 latch reset", 0, 8'hFF, 8'h00);
    step();
    cfg_analog_hi = 1'b1; cfg_bus_lo = 1'b1; cfg_pwm_route_n = 1'b1; pwm_en = 1'b0;
    rst_n = 1'b1;
    step(); step();
    // R5/R6: synchronizer lag, analog bits read as zero
    pad_in = 8'hFF; reg_addr = 2'd0;
    expect_out("R5 lag0", 0, 8'hFF, 8'h00);
    step();
    expect_out("R5 lag1", 0, 8'hFF, 8'h00);
    step();
    expect_out("R5 R6 lag2 analog zero", 0, 8'hFF, 8'h0F);
    expect_out("R6 R7 oe", 2, 8'hFF, 8'h0F);
    step();
    // R9: config change one edge late
    cfg_analog_hi = 1'b0; cfg_bus_lo = 1'b0;
    expect_out("R9 oe old cfg", 2, 8'hFF, 8'h0F);
    expect_out("R9 read old cfg", 0, 8'hFF, 8'h0F);
    step();
    expect_out("R9 R6 read gpio", 0, 8'hFF, 8'hFF);
    expect_out("R2 R9 all inputs", 2, 8'hFF, 8'h00);
    // R2: direction and latch drive
    wr(2'd2, 8'h0F);
    wr(2'd1, 8'hA5);
    expect_out("R2 oe", 2, 8'hFF, 8'hF0);
    expect_out("R2 out", 1, 8'hF0, 8'hA0);
    // R3: port address write loads latch; latch read is not pin level
    wr(2'd0, 8'h3C);
    reg_addr = 2'd1; pad_in = 8'h00;
    expect_out("R3 latch read", 0, 8'hFF, 8'h3C);
    expect_out("R3 out", 1, 8'hF0, 8'h30);
    step(); step(); reg_addr = 2'd0;
    expect_out("R3 port read pins", 0, 8'hFF, 8'h00);
    step(); reg_addr = 2'd1;
    expect_out("R3 latch kept", 0, 8'hFF, 8'h3C);
    // R4: address 3 write ignored, read 0
    wr(2'd3, 8'h55);
    reg_addr = 2'd1;
    expect_out("R4 latch untouched", 0, 8'hFF, 8'h3C);
    step(); reg_addr = 2'd2;
    expect_out("R4 dir untouched", 0, 8'hFF, 8'h0F);
    step(); reg_addr = 2'd3;
    expect_out("R4 addr3 zero", 0, 8'hFF, 8'h00);
    wr(2'd2, 8'hFF);
    expect_out("R2 all released", 2, 8'hFF, 8'h00);
    // R8: PWM routing over analog
    step();
    cfg_pwm_route_n = 1'b0; pwm_en = 1'b1; pwm_b = 1'b1; pwm_c = 1'b0; cfg_analog_hi = 1'b1;
    step();
    expect_out("R8 oe", 2, 8'hFF, 8'hC0);
    expect_out("R8 out", 1, 8'hC0, 8'h80);
    step();
    pwm_b = 1'b0; pwm_c = 1'b1;
    expect_out("R8 out follows", 1, 8'hC0, 8'h40);
    step();
    pwm_en = 1'b0;
    expect_out("R8 disabled", 2, 8'hFF, 8'h00);
    // R7: bus mode overrides direction
    cfg_bus_lo = 1'b1; ext_addr_hi = 4'h5;
    step();
    expect_out("R7 oe", 2, 8'h0F, 8'h0F);
    expect_out("R7 out", 1, 8'h0F, 8'h05);
    step();
    ext_addr_hi = 4'h3;
    expect_out("R7 out follows", 1, 8'h0F, 8'h03);
    step(); step();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule